// File: doc/BRIEF.md
# USB Slave-FIFO Bridge Controller

This block sits between FPGA fabric and the synchronous 32-bit slave-FIFO port of a USB 3.0 peripheral controller. It moves exactly one fixed packet of 256 words (1024 bytes) for each start request. The direction of the packet comes from a static level on a command input that behaves like a serial receive line. In the upload direction the block writes words into the USB chip. The words come either from a local source over a valid/ready handshake or from a built-in counting pattern. In the download direction it reads words out of the USB chip and hands them to a local sink over a valid/ready handshake.

The controller drives the chip's active-low select, output-enable, read and write strobes, and it honours the chip's "not full" and "not empty" flags. It can stall at any point inside a packet and resume with no lost or repeated word. A small checker watches the downloaded stream and flags any word whose lower 16 bits do not continue the counting sequence. This lets a host-generated ramp be verified in the fabric.

Top module: `usb_sfifo_bridge`

## Requirements
- R1: While reset is applied, and afterwards until a start request, `usb_cs_n`, `usb_oe_n`, `usb_rd_n` and `usb_wr_n` are high, and `usb_dq_oe`, `src_ready`, `snk_valid`, `pkt_done` and `seq_err` are low.
- R2: A start request (`go` high in the idle state) latches `cmd_rx` (1 = upload, 0 = download) and `pat_sel`. The next cycle is a setup cycle with `usb_cs_n` low and no strobe. In that cycle `usb_dq_oe` is high for upload, and `usb_oe_n` is low for download.
- R3: A packet ends after exactly 256 strobed words. It then spends one cycle with `pkt_done` high and `usb_cs_n` high, and returns to idle.
- R4: During an upload packet `usb_dq_oe` stays high and `usb_oe_n` stays high, so the block never drives the bus while the chip is enabled to drive it.
- R5: `usb_wr_n` is low only in cycles where `usb_full_n` is high and a word is available. A drop of `usb_full_n` mid-packet pauses the stream, which resumes with no skipped or repeated word.
- R6: In pattern mode the uploaded word is 0 in bits 31:16 and a count in bits 15:0. The count is 0 on the first word of every packet and rises by 1 per word to 255. `src_ready` stays low and `src_valid` is not needed.
- R7: In buffer mode `usb_dq_o` equals `src_data`, and `src_ready` is high exactly in the cycles where `usb_wr_n` is low, so the source words appear on the bus in order.
- R8: During a download packet `usb_oe_n` is low from the setup cycle to the last word, so it is low at least one cycle before the first read strobe. `usb_rd_n` is low only when `usb_empty_n` and `snk_ready` are both high.
- R9: `snk_valid` is high exactly in the cycles where `usb_rd_n` is low, and `snk_data` then equals `usb_dq_i`.
- R10: A change of `cmd_rx` while a packet is in progress has no effect on that packet. The strobe of the latched direction continues, the other strobe stays high, and 256 words still complete.
- R11: `seq_err` pulses for one cycle, in the cycle after a downloaded word, when that word's bits 15:0 are not the previous downloaded word's value plus 1. After a previous value of 255 the expected value is 0. The first downloaded word after reset is exempt.
- R12: `usb_cs_n` stays low for the whole packet from setup to the last word, no strobe is low while it is high, and the two strobes are never low together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go | input | 1 | Start one packet when idle |
| cmd_rx | input | 1 | Direction level: 1 upload, 0 download |
| pat_sel | input | 1 | Upload from counting pattern instead of local source |
| src_data | input | 32 | Local source word |
| src_valid | input | 1 | Local source word available |
| src_ready | output | 1 | Local source word consumed this cycle |
| snk_data | output | 32 | Word delivered to local sink |
| snk_valid | output | 1 | Sink word valid this cycle |
| snk_ready | input | 1 | Sink can accept a word |
| usb_cs_n | output | 1 | Chip select, active low |
| usb_oe_n | output | 1 | Chip output enable, active low |
| usb_rd_n | output | 1 | Read strobe, active low |
| usb_wr_n | output | 1 | Write strobe, active low |
| usb_dq_o | output | 32 | Data toward the chip |
| usb_dq_oe | output | 1 | Block drives the data bus |
| usb_dq_i | input | 32 | Data from the chip |
| usb_full_n | input | 1 | Chip FIFO has space |
| usb_empty_n | input | 1 | Chip FIFO has data |
| pkt_done | output | 1 | One-cycle packet completion marker |
| seq_err | output | 1 | Downloaded sequence break |

## Verification
The assertions assume that `rst_n` is held low long enough for the internal reset synchronizer to clear, and that a word is moved only on the edge where a strobe is low. They also assume that the flags and handshake inputs change only between edges. The stimulus drives every input on the falling edge and samples just after it. It toggles `usb_full_n`, `usb_empty_n`, `src_valid` and `snk_ready` in fixed repeating patterns that create mid-packet stalls. It flips `cmd_rx` only inside packets, to exercise the hold of the latched direction.

// File: rtl/usb_sfifo_pkg.sv
package usb_sfifo_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_XFER  = 2'd2,
    ST_DONE  = 2'd3
  } brg_state_t;

  typedef enum logic {
    DIR_DOWN = 1'b0,
    DIR_UP   = 1'b1
  } brg_dir_t;

endpackage

// File: rtl/bridge_fsm.sv
module bridge_fsm
  import usb_sfifo_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic       cmd_rx,
  input  logic       pat_sel,
  input  logic       last_beat,
  output brg_state_t state,
  output brg_dir_t   dir_q,
  output logic       pat_q
);

  brg_state_t state_nxt;
  logic       latch_en;

  assign latch_en = (state == ST_IDLE) && go;

  always_comb begin
    state_nxt = state;
    case (state)
      ST_IDLE:  if (go) state_nxt = ST_SETUP;
      ST_SETUP: state_nxt = ST_XFER;
      ST_XFER:  if (last_beat) state_nxt = ST_DONE;
      ST_DONE:  state_nxt = ST_IDLE;
      default:  state_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
    end else begin
      state <= state_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= DIR_DOWN;
      pat_q <= 1'b0;
    end else if (latch_en) begin
      dir_q <= brg_dir_t'(cmd_rx);
      pat_q <= pat_sel;
    end
  end

endmodule

// File: rtl/bridge_wcnt.sv
module bridge_wcnt #(
  parameter int PKT_WORDS = 256,
  localparam int CNT_W    = $clog2(PKT_WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat,
  output logic [CNT_W-1:0] cnt,
  output logic             last_beat
);

  logic [CNT_W-1:0] cnt_nxt;

  assign last_beat = beat && (cnt == CNT_W'(PKT_WORDS - 1));

  always_comb begin
    cnt_nxt = cnt;
    if (last_beat) begin
      cnt_nxt = '0;
    end else if (beat) begin
      cnt_nxt = cnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else begin
      cnt <= cnt_nxt;
    end
  end

endmodule

// File: rtl/bridge_seqchk.sv
module bridge_seqchk #(
  parameter int LOW_W     = 16,
  parameter int PKT_WORDS = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat,
  input  logic [LOW_W-1:0] word_low,
  output logic             err
);

  logic [LOW_W-1:0] prev;
  logic             has_prev;
  logic [LOW_W-1:0] expect_low;
  logic             err_nxt;

  always_comb begin
    if (prev == LOW_W'(PKT_WORDS - 1)) begin
      expect_low = '0;
    end else begin
      expect_low = prev + LOW_W'(1);
    end
    err_nxt = beat && has_prev && (word_low != expect_low);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev     <= '0;
      has_prev <= 1'b0;
    end else if (beat) begin
      prev     <= word_low;
      has_prev <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err <= 1'b0;
    end else begin
      err <= err_nxt;
    end
  end

endmodule

// File: rtl/usb_sfifo_bridge.sv
module usb_sfifo_bridge
  import usb_sfifo_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int LOW_W     = 16,
  parameter int PKT_WORDS = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              cmd_rx,
  input  logic              pat_sel,
  input  logic [DATA_W-1:0] src_data,
  input  logic              src_valid,
  output logic              src_ready,
  output logic [DATA_W-1:0] snk_data,
  output logic              snk_valid,
  input  logic              snk_ready,
  output logic              usb_cs_n,
  output logic              usb_oe_n,
  output logic              usb_rd_n,
  output logic              usb_wr_n,
  output logic [DATA_W-1:0] usb_dq_o,
  output logic              usb_dq_oe,
  input  logic [DATA_W-1:0] usb_dq_i,
  input  logic              usb_full_n,
  input  logic              usb_empty_n,
  output logic              pkt_done,
  output logic              seq_err
);

  localparam int CNT_W = $clog2(PKT_WORDS);

  logic             rst_meta, rst_sync;
  brg_state_t       state;
  brg_dir_t         dir_q;
  logic             pat_q;
  logic             last_beat;
  logic [CNT_W-1:0] wcnt;
  logic             sel_active, xfer_active, dir_up;
  logic             word_avail, wr_beat, rd_beat, beat;
  logic [DATA_W-1:0] pat_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  bridge_fsm i_fsm (
    .clk       (clk),
    .rst_n     (rst_sync),
    .go        (go),
    .cmd_rx    (cmd_rx),
    .pat_sel   (pat_sel),
    .last_beat (last_beat),
    .state     (state),
    .dir_q     (dir_q),
    .pat_q     (pat_q)
  );

  bridge_wcnt #(.PKT_WORDS(PKT_WORDS)) i_wcnt (
    .clk       (clk),
    .rst_n     (rst_sync),
    .beat      (beat),
    .cnt       (wcnt),
    .last_beat (last_beat)
  );

  bridge_seqchk #(.LOW_W(LOW_W), .PKT_WORDS(PKT_WORDS)) i_seqchk (
    .clk      (clk),
    .rst_n    (rst_sync),
    .beat     (rd_beat),
    .word_low (usb_dq_i[LOW_W-1:0]),
    .err      (seq_err)
  );

  always_comb begin
    sel_active  = (state == ST_SETUP) || (state == ST_XFER);
    xfer_active = (state == ST_XFER);
    dir_up      = (dir_q == DIR_UP);
    word_avail  = pat_q || src_valid;
    wr_beat     = xfer_active && dir_up && usb_full_n && word_avail;
    rd_beat     = xfer_active && !dir_up && usb_empty_n && snk_ready;
    beat        = wr_beat || rd_beat;
    pat_word    = {{(DATA_W-LOW_W){1'b0}}, LOW_W'(wcnt)};
  end

  always_comb begin
    usb_cs_n  = !sel_active;
    usb_oe_n  = !(sel_active && !dir_up);
    usb_dq_oe = sel_active && dir_up;
    usb_wr_n  = !wr_beat;
    usb_rd_n  = !rd_beat;
    usb_dq_o  = pat_q ? pat_word : src_data;
    src_ready = wr_beat && !pat_q;
    snk_valid = rd_beat;
    snk_data  = usb_dq_i;
    pkt_done  = (state == ST_DONE);
  end

endmodule

// File: rtl/usb_sfifo_bridge_chk.sv
module usb_sfifo_bridge_chk #(
  parameter int PKT_WORDS = 256,
  localparam int CW       = $clog2(PKT_WORDS + 1)
) (
  input logic clk,
  input logic rst_n,
  input logic usb_cs_n,
  input logic usb_oe_n,
  input logic usb_rd_n,
  input logic usb_wr_n,
  input logic usb_dq_oe,
  input logic usb_full_n,
  input logic usb_empty_n,
  input logic pkt_done
);

  logic [CW-1:0] beats;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beats <= '0;
    end else if (pkt_done) begin
      beats <= '0;
    end else if (!usb_wr_n || !usb_rd_n) begin
      beats <= beats + CW'(1);
    end
  end

  AST_DONE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done |-> (beats == CW'(PKT_WORDS))); // R3
  AST_DONE_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done |-> usb_cs_n); // R3
  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
    usb_dq_oe |-> usb_oe_n); // R4
  AST_WR_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
    !usb_wr_n |-> usb_full_n); // R5
  AST_RD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    !usb_rd_n |-> usb_empty_n); // R8
  AST_OE_LEADS_RD: assert property (@(posedge clk) disable iff (!rst_n)
    !usb_rd_n |-> $past(!usb_oe_n)); // R8
  AST_DIR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!usb_cs_n && $past(!usb_cs_n)) |-> ($stable(usb_oe_n) && $stable(usb_dq_oe))); // R10
  AST_STROBE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    (!usb_wr_n || !usb_rd_n) |-> !usb_cs_n); // R12
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({!usb_wr_n, !usb_rd_n}) <= 1); // R12

endmodule

bind usb_sfifo_bridge usb_sfifo_bridge_chk #(.PKT_WORDS(PKT_WORDS)) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .usb_cs_n    (usb_cs_n),
  .usb_oe_n    (usb_oe_n),
  .usb_rd_n    (usb_rd_n),
  .usb_wr_n    (usb_wr_n),
  .usb_dq_oe   (usb_dq_oe),
  .usb_full_n  (usb_full_n),
  .usb_empty_n (usb_empty_n),
  .pkt_done    (pkt_done)
);

// File: tb/test_usb_sfifo_bridge.sv
module test_usb_sfifo_bridge;

  logic        clk;
  logic        rst_n;
  logic        go, cmd_rx, pat_sel;
  logic [31:0] src_data;
  logic        src_valid, src_ready;
  logic [31:0] snk_data;
  logic        snk_valid, snk_ready;
  logic        usb_cs_n, usb_oe_n, usb_rd_n, usb_wr_n;
  logic [31:0] usb_dq_o;
  logic        usb_dq_oe;
  logic [31:0] usb_dq_i;
  logic        usb_full_n, usb_empty_n;
  logic        pkt_done, seq_err;

  int n_chk;
  int n_fail;
  bit has_prev;
  logic [15:0] prev_low;

  usb_sfifo_bridge i_usb_sfifo_bridge (
    .clk(clk), .rst_n(rst_n), .go(go), .cmd_rx(cmd_rx), .pat_sel(pat_sel),
    .src_data(src_data), .src_valid(src_valid), .src_ready(src_ready),
    .snk_data(snk_data), .snk_valid(snk_valid), .snk_ready(snk_ready),
    .usb_cs_n(usb_cs_n), .usb_oe_n(usb_oe_n), .usb_rd_n(usb_rd_n),
    .usb_wr_n(usb_wr_n), .usb_dq_o(usb_dq_o), .usb_dq_oe(usb_dq_oe),
    .usb_dq_i(usb_dq_i), .usb_full_n(usb_full_n), .usb_empty_n(usb_empty_n),
    .pkt_done(pkt_done), .seq_err(seq_err)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic chk_idle(input string tag);
    chk(usb_cs_n && usb_oe_n && usb_rd_n && usb_wr_n, tag,
        {usb_cs_n, usb_oe_n, usb_rd_n, usb_wr_n}, 4'hF);
    chk(!usb_dq_oe && !src_ready && !snk_valid && !pkt_done && !seq_err, tag,
        {usb_dq_oe, src_ready, snk_valid, pkt_done, seq_err}, 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; go = 0; cmd_rx = 0; pat_sel = 0; src_data = 0; src_valid = 0;
    snk_ready = 0; usb_dq_i = 0; usb_full_n = 1; usb_empty_n = 1;
    has_prev = 0; prev_low = 0;
    repeat (3) @(negedge clk);
    #1 chk_idle("R1 in reset");
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1 chk_idle("R1 after reset");
  endtask

  task automatic t_upload(input bit pat, input bit stall, input bit flip);
    int beats;
    int k;
    bit done;
    logic [31:0] base;
    beats = 0; k = 0; done = 0; base = 32'hA500_0000;
    @(negedge clk);
    cmd_rx = 1; pat_sel = pat; go = 1; usb_full_n = 1; src_valid = !pat;
    src_data = base;
    @(negedge clk);
    go = 0; pat_sel = !pat;
    #1;
    chk(!usb_cs_n && usb_wr_n && usb_dq_oe && usb_oe_n, "R2 upload setup",
        {usb_cs_n, usb_wr_n, usb_dq_oe, usb_oe_n}, 4'b0111);
    for (int i = 0; i < 2000 && !done; i++) begin
      @(negedge clk);
      usb_full_n = stall ? ((i % 5) != 2) : 1'b1;
      src_valid  = pat ? 1'b0 : (stall ? ((i % 3) != 1) : 1'b1);
      src_data   = base + k;
      if (flip && i == 50) cmd_rx = 0;
      #1;
      if (pkt_done) begin
        chk(beats == 256, "R3 upload word count", beats, 256);
        chk(usb_cs_n && usb_wr_n, "R3 deselect at done", {usb_cs_n, usb_wr_n}, 2'b11);
        done = 1;
      end else begin
        chk(!usb_cs_n, "R12 select held", usb_cs_n, 0);
        chk(usb_dq_oe && usb_oe_n, "R4 bus direction", {usb_dq_oe, usb_oe_n}, 2'b11);
        chk(usb_rd_n, "R10 no read strobe in upload", usb_rd_n, 1);
        if (!usb_full_n || (!pat && !src_valid))
          chk(usb_wr_n, "R5 stall respected", usb_wr_n, 1);
        if (!pat) chk(src_ready == !usb_wr_n, "R7 ready tracks strobe", src_ready, !usb_wr_n);
        else chk(!src_ready, "R6 ready low in pattern", src_ready, 0);
        if (!usb_wr_n) begin
          if (pat) chk(usb_dq_o == 32'(beats), "R6 pattern word", usb_dq_o, beats);
          else chk(usb_dq_o == base + beats, "R7 source word order", usb_dq_o, base + beats);
          beats++;
          if (!pat) k++;
        end
      end
    end
    chk(done, "R3 upload completed", done, 1);
    @(negedge clk);
    src_valid = 0; cmd_rx = 1;
    #1 chk_idle("R3 idle after upload");
  endtask

  task automatic t_download(input bit stall, input bit inject);
    int beats;
    int n_err;
    bit pend;
    bit done;
    bit seen_oe;
    logic [15:0] low;
    beats = 0; n_err = 0; pend = 0; done = 0; seen_oe = 0;
    @(negedge clk);
    cmd_rx = 0; go = 1; usb_empty_n = 1; snk_ready = 1;
    @(negedge clk);
    go = 0;
    #1;
    chk(!usb_cs_n && !usb_oe_n && usb_rd_n && !usb_dq_oe, "R8 download setup",
        {usb_cs_n, usb_oe_n, usb_rd_n, usb_dq_oe}, 4'b0010);
    seen_oe = !usb_oe_n;
    for (int i = 0; i < 2000 && !done; i++) begin
      @(negedge clk);
      usb_empty_n = stall ? ((i % 4) != 1) : 1'b1;
      snk_ready   = stall ? ((i % 6) != 4) : 1'b1;
      if (stall && i == 40) cmd_rx = 1;
      low = 16'(beats) + ((inject && beats >= 100) ? 16'd1 : 16'd0);
      usb_dq_i = {16'hC3C3, low};
      #1;
      chk(seq_err == pend, "R11 sequence flag", seq_err, pend);
      if (pend) n_err++;
      pend = 0;
      chk(snk_valid == !usb_rd_n, "R9 sink valid", snk_valid, !usb_rd_n);
      if (pkt_done) begin
        chk(beats == 256, "R3 download word count", beats, 256);
        chk(usb_cs_n && usb_oe_n, "R3 release at done", {usb_cs_n, usb_oe_n}, 2'b11);
        done = 1;
      end else begin
        chk(!usb_cs_n && !usb_oe_n, "R8 select and enable held", {usb_cs_n, usb_oe_n}, 0);
        chk(usb_wr_n && !usb_dq_oe, "R10 no write in download", {usb_wr_n, usb_dq_oe}, 2'b10);
        if (!usb_empty_n || !snk_ready)
          chk(usb_rd_n, "R8 read stall", usb_rd_n, 1);
        if (!usb_rd_n) begin
          chk(seen_oe, "R8 enable before read", seen_oe, 1);
          chk(snk_data == usb_dq_i, "R9 sink data", snk_data, usb_dq_i);
          pend = has_prev && (low != ((prev_low == 16'd255) ? 16'd0 : prev_low + 16'd1));
          prev_low = low; has_prev = 1;
          beats++;
        end
        seen_oe = !usb_oe_n;
      end
    end
    chk(done, "R3 download completed", done, 1);
    if (inject) chk(n_err > 0, "R11 break detected", n_err, 1);
    else chk(n_err == 0, "R11 clean stream", n_err, 0);
    @(negedge clk);
    cmd_rx = 0;
    #1 chk_idle("R3 idle after download");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    n_chk = 0; n_fail = 0;
    t_reset();
    t_upload(1'b1, 1'b0, 1'b0);
    t_upload(1'b1, 1'b1, 1'b0);
    t_upload(1'b0, 1'b1, 1'b1);
    t_upload(1'b0, 1'b0, 1'b0);
    t_download(1'b0, 1'b0);
    t_download(1'b1, 1'b0);
    t_download(1'b0, 1'b1);
    finish_run();
  end

endmodule